// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface and owns the command pins from reset release until the memory is ready for normal traffic. It keeps clock enable low and drives NOP while the clock settles. It then raises clock enable and steps through a fixed list of commands: precharge-all, programming of all four mode registers, a DLL reset, a second precharge-all, a train of auto-refreshes, the final main mode write, and an output-driver calibration default-then-exit pair. Each command is separated from the next by a gap measured in clock cycles.

Every wait is given in picoseconds or clock cycles as a parameter. It is turned into a cycle count from the clock-period parameter, rounded up, and never less than one. The mode field values (CAS latency, additive latency, burst length code, write recovery code and termination code) are plain inputs. They are sampled in the cycle where each mode write is issued. After the last calibration-exit write has had its spacing, `initDone` goes high and stays high. The normal-operation scheduler then takes over the bus.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted and after its release, `memCke` is low, `memOdt` is low, `initDone` is low and the command is NOP. `memCke` stays low for at least the stable-clock time (20000 cycles at the default 10 ns period and 200 us).
- R2: `memCke` rises while NOP is driven. The first command is a precharge-all, no earlier than the post-enable time (40 cycles at default).
- R3: Commands are coded on {csN,rasN,casN,weN}: NOP = 0111, precharge-all = 0010 with A10 = 1, mode write = 0000, auto-refresh = 0001. BA selects the mode register: 0 main, 1 ext1, 2 ext2, 3 ext3. The issue order is fixed:
  1. precharge-all
  2. ext2
  3. ext3
  4. ext1 with DLL enabled (A0 = 0)
  5. main with A8 = 1
  6. precharge-all
  7. the auto-refresh train
  8. main with A8 = 0
  9. ext1 with A9..A7 = 111
  10. ext1 with A9..A7 = 000
- R4: Main mode word fields:
  - burst length code on A2..A0
  - A3 = 0
  - CAS latency on A6..A4
  - A7 = 0
  - DLL reset on A8
  - write recovery code on A11..A9
  - A12 = 0
  - A13 = 0
- R5: Ext1 word fields:
  - A0 = 0 and A1 = 0
  - termination code bit 0 on A2 and bit 1 on A6
  - additive latency on A5..A3
  - calibration code on A9..A7
  - A10 through A13 = 0
  
  The ext2 and ext3 words are all zero.
- R6: Any two consecutive mode writes are at least 2 cycles apart.
- R7: After a precharge-all, the next command waits at least the precharge time (2 cycles at default). After an auto-refresh, the next command waits at least the refresh cycle time (13 cycles at default).
- R8: The calibration-default write comes at least 200 cycles after the second precharge-all.
- R9: `initDone` rises no sooner than 2 cycles after the calibration-exit write. It then stays high and the command stays NOP.
- R10: `memOdt` is low throughout.
- R11: Exactly `NUM_REF` auto-refreshes are issued (parameter, minimum 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCasLat | input | 3 | CAS latency field code |
| cfgAddLat | input | 3 | Additive latency field code |
| cfgBurstLen | input | 3 | Burst length field code |
| cfgWrRec | input | 3 | Write recovery field code |
| cfgRtt | input | 2 | Termination code {bit for A6, bit for A2} |
| memCke | output | 1 | Clock enable |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBa | output | BA_W | Bank / mode register select |
| memAddr | output | ADDR_W | Address / mode word |
| memOdt | output | 1 | On-die termination enable, held low |
| initDone | output | 1 | Initialization complete, sticky |

## Verification
The hardest point to reach from the ports is the calibration-default write. Its timing depends on two overlapping rules: the 200-cycle window counted from the second precharge-all, and the mode-write spacing after the final main write. The bench gets there by running the whole 20000-cycle power-up wait with three refreshes. The refresh train then ends long before the window closes, so the window alone sets the gap.

A scoreboard compares every issued command against its expected place in the order, its field values and its minimum gap. The run is then repeated after a reset that arrives while `initDone` is high, with every field value changed, to show that the sequence restarts from scratch.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
package ddr2_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PREA,
    CMD_MRS,
    CMD_REF
  } cmdT;

  localparam logic [1:0] SEL_MR   = 2'd0;
  localparam logic [1:0] SEL_EMR1 = 2'd1;
  localparam logic [1:0] SEL_EMR2 = 2'd2;
  localparam logic [1:0] SEL_EMR3 = 2'd3;

  // Strobes from the sequencing control to the command datapath
  typedef struct packed {
    logic       ckeOn;
    logic       issue;
    cmdT        cmd;
    logic [1:0] regSel;
    logic       dllRst;
    logic [2:0] ocdCode;
    logic       done;
  } seqStrbT;

  function automatic int cdiv(int num, int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int atLeast1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int maxInt(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr2_init_ctrl.sv
`timescale 1ns/1ps
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int CLK_PS      = 10000,
  parameter int T_STABLE_PS = 200000000,
  parameter int T_CKE_PS    = 400000,
  parameter int T_RP_PS     = 15000,
  parameter int T_RFC_PS    = 127500,
  parameter int T_MRD_CK    = 2,
  parameter int OCD_GAP_CK  = 200,
  parameter int NUM_REF     = 2
) (
  input  logic    clk,
  input  logic    rstN,
  output seqStrbT strb
);

  localparam int STABLE_CYC = atLeast1(cdiv(T_STABLE_PS, CLK_PS));
  localparam int CKE_CYC    = atLeast1(cdiv(T_CKE_PS, CLK_PS));
  localparam int RP_CYC     = atLeast1(cdiv(T_RP_PS, CLK_PS));
  localparam int RFC_CYC    = atLeast1(cdiv(T_RFC_PS, CLK_PS));
  localparam int MRD_CYC    = atLeast1(T_MRD_CK);
  localparam int OCD_CYC    = atLeast1(OCD_GAP_CK);
  localparam int MAX_WAIT   = maxInt(maxInt(STABLE_CYC, CKE_CYC),
                                     maxInt(RFC_CYC, maxInt(RP_CYC, MRD_CYC)));
  localparam int WAIT_W     = $clog2(MAX_WAIT + 1);
  localparam int OCD_W      = $clog2(OCD_CYC + 1);
  localparam int REF_W      = $clog2(NUM_REF + 1);
  localparam int MRS_W      = $clog2(MRD_CYC + 1);

  typedef enum logic [3:0] {
    S_STABLE, S_CKE, S_PRE1, S_EMR2, S_EMR3, S_EMR1_DLL, S_MR_RST,
    S_PRE2, S_REF, S_MR_RUN, S_OCD_DFLT, S_OCD_EXIT, S_DONE
  } stepT;

  stepT              step, nextStep;
  logic [WAIT_W-1:0] waitQ, gapCyc;
  logic [OCD_W-1:0]  ocdCntQ;
  logic [REF_W-1:0]  refCntQ;
  logic              ckeOnQ;
  logic              zero, ocdReady;

  assign zero     = (waitQ == '0);
  assign ocdReady = (ocdCntQ == OCD_W'(OCD_CYC));

  always_comb begin
    strb        = '0;
    strb.ckeOn  = ckeOnQ;
    strb.cmd    = CMD_NOP;
    strb.regSel = SEL_MR;
    gapCyc      = WAIT_W'(MRD_CYC);
    nextStep    = step;
    unique case (step)
      S_PRE1, S_PRE2: begin
        strb.cmd   = CMD_PREA;
        strb.issue = zero;
        gapCyc     = WAIT_W'(RP_CYC);
        nextStep   = (step == S_PRE1) ? S_EMR2 : S_REF;
      end
      S_EMR2: begin
        strb.cmd = CMD_MRS; strb.regSel = SEL_EMR2;
        strb.issue = zero;  nextStep = S_EMR3;
      end
      S_EMR3: begin
        strb.cmd = CMD_MRS; strb.regSel = SEL_EMR3;
        strb.issue = zero;  nextStep = S_EMR1_DLL;
      end
      S_EMR1_DLL: begin
        strb.cmd = CMD_MRS; strb.regSel = SEL_EMR1;
        strb.issue = zero;  nextStep = S_MR_RST;
      end
      S_MR_RST: begin
        strb.cmd = CMD_MRS; strb.dllRst = 1'b1;
        strb.issue = zero;  nextStep = S_PRE2;
      end
      S_REF: begin
        strb.cmd   = CMD_REF;
        strb.issue = zero;
        gapCyc     = WAIT_W'(RFC_CYC);
        nextStep   = (refCntQ == REF_W'(NUM_REF - 1)) ? S_MR_RUN : S_REF;
      end
      S_MR_RUN: begin
        strb.cmd = CMD_MRS;
        strb.issue = zero; nextStep = S_OCD_DFLT;
      end
      S_OCD_DFLT: begin
        strb.cmd = CMD_MRS; strb.regSel = SEL_EMR1; strb.ocdCode = 3'b111;
        strb.issue = zero && ocdReady; nextStep = S_OCD_EXIT;
      end
      S_OCD_EXIT: begin
        strb.cmd = CMD_MRS; strb.regSel = SEL_EMR1;
        strb.issue = zero;  nextStep = S_DONE;
      end
      S_DONE:  strb.done = zero;
      default: ;
    endcase
    if (!strb.issue) strb.cmd = CMD_NOP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step    <= S_STABLE;
      waitQ   <= WAIT_W'(STABLE_CYC - 1);
      ckeOnQ  <= 1'b0;
      refCntQ <= '0;
      ocdCntQ <= '0;
    end else begin
      if (step == S_PRE2 && strb.issue)
        ocdCntQ <= OCD_W'(1);
      else if (ocdCntQ != '0 && !ocdReady)
        ocdCntQ <= ocdCntQ + 1'b1;

      if (step == S_REF && strb.issue) refCntQ <= refCntQ + 1'b1;

      unique case (step)
        S_STABLE: begin
          if (zero) begin
            step   <= S_CKE;
            waitQ  <= WAIT_W'(CKE_CYC - 1);
            ckeOnQ <= 1'b1;
          end else waitQ <= waitQ - 1'b1;
        end
        S_CKE: begin
          if (zero) step <= S_PRE1;
          else      waitQ <= waitQ - 1'b1;
        end
        S_DONE: begin
          if (!zero) waitQ <= waitQ - 1'b1;
        end
        default: begin
          if (strb.issue) begin
            waitQ <= gapCyc - 1'b1;
            step  <= nextStep;
          end else if (!zero) waitQ <= waitQ - 1'b1;
        end
      endcase
    end
  end

  // Checker state: cycles since the last mode write, saturating
  logic [MRS_W-1:0] sinceMrsQ;
  logic             mrsSeenQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceMrsQ <= '0;
      mrsSeenQ  <= 1'b0;
    end else if (strb.issue && strb.cmd == CMD_MRS) begin
      sinceMrsQ <= MRS_W'(1);
      mrsSeenQ  <= 1'b1;
    end else if (sinceMrsQ != MRS_W'(MRD_CYC)) begin
      sinceMrsQ <= sinceMrsQ + 1'b1;
    end
  end

  // R6
  mrs_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && strb.cmd == CMD_MRS && mrsSeenQ) |-> sinceMrsQ == MRS_W'(MRD_CYC));

  // R2
  cmd_after_cke_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> ckeOnQ);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> strb.done);

  // R11
  ref_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    refCntQ <= REF_W'(NUM_REF));

endmodule

// File: rtl/ddr2_init_dp.sv
`timescale 1ns/1ps
module ddr2_init_dp
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrbT           strb,
  input  logic [2:0]        cfgCasLat,
  input  logic [2:0]        cfgAddLat,
  input  logic [2:0]        cfgBurstLen,
  input  logic [2:0]        cfgWrRec,
  input  logic [1:0]        cfgRtt,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [BA_W-1:0]   memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initDone
);

  logic [ADDR_W-1:0] mrWord, emr1Word, addrNext;
  logic [BA_W-1:0]   baNext;
  logic [3:0]        pinsNext;
  cmdT               cmdEff;

  assign cmdEff = strb.issue ? strb.cmd : CMD_NOP;

  always_comb begin
    mrWord         = '0;
    mrWord[2:0]    = cfgBurstLen;
    mrWord[6:4]    = cfgCasLat;
    mrWord[8]      = strb.dllRst;
    mrWord[11:9]   = cfgWrRec;

    emr1Word       = '0;
    emr1Word[2]    = cfgRtt[0];
    emr1Word[5:3]  = cfgAddLat;
    emr1Word[6]    = cfgRtt[1];
    emr1Word[9:7]  = strb.ocdCode;
  end

  always_comb begin
    pinsNext = 4'b0111;
    addrNext = '0;
    baNext   = '0;
    unique case (cmdEff)
      CMD_PREA: begin
        pinsNext     = 4'b0010;
        addrNext[10] = 1'b1;
      end
      CMD_MRS: begin
        pinsNext = 4'b0000;
        baNext   = BA_W'(strb.regSel);
        if (strb.regSel == SEL_MR)        addrNext = mrWord;
        else if (strb.regSel == SEL_EMR1) addrNext = emr1Word;
      end
      CMD_REF: pinsNext = 4'b0001;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCke   <= 1'b0;
      {memCsN, memRasN, memCasN, memWeN} <= 4'b0111;
      memBa    <= '0;
      memAddr  <= '0;
      initDone <= 1'b0;
    end else begin
      memCke   <= strb.ckeOn;
      {memCsN, memRasN, memCasN, memWeN} <= pinsNext;
      memBa    <= baNext;
      memAddr  <= addrNext;
      initDone <= strb.done;
    end
  end

  // R1
  nop_while_cke_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memCke |-> ({memCsN, memRasN, memCasN, memWeN} == 4'b0111));

  // R9
  nop_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> ({memCsN, memRasN, memCasN, memWeN} == 4'b0111));

  // R9
  done_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_PS      = 10000,
  parameter int T_STABLE_PS = 200000000,
  parameter int T_CKE_PS    = 400000,
  parameter int T_RP_PS     = 15000,
  parameter int T_RFC_PS    = 127500,
  parameter int T_MRD_CK    = 2,
  parameter int OCD_GAP_CK  = 200,
  parameter int NUM_REF     = 2,
  parameter int ADDR_W      = 14,
  parameter int BA_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgCasLat,
  input  logic [2:0]        cfgAddLat,
  input  logic [2:0]        cfgBurstLen,
  input  logic [2:0]        cfgWrRec,
  input  logic [1:0]        cfgRtt,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [BA_W-1:0]   memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memOdt,
  output logic              initDone
);

  seqStrbT strb;

  ddr2_init_ctrl #(
    .CLK_PS(CLK_PS), .T_STABLE_PS(T_STABLE_PS), .T_CKE_PS(T_CKE_PS),
    .T_RP_PS(T_RP_PS), .T_RFC_PS(T_RFC_PS), .T_MRD_CK(T_MRD_CK),
    .OCD_GAP_CK(OCD_GAP_CK), .NUM_REF(NUM_REF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .strb(strb)
  );

  ddr2_init_dp #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgCasLat(cfgCasLat), .cfgAddLat(cfgAddLat), .cfgBurstLen(cfgBurstLen),
    .cfgWrRec(cfgWrRec), .cfgRtt(cfgRtt),
    .memCke(memCke), .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN),
    .memWeN(memWeN), .memBa(memBa), .memAddr(memAddr), .initDone(initDone)
  );

  // Termination stays off for the whole power-up sequence
  assign memOdt = 1'b0;

endmodule

// File: tb/ddr2_init_seq_bench.sv
`timescale 1ns/1ps
module ddr2_init_seq_bench;

  localparam int NREF       = 3;
  localparam int STABLE_MIN = 20000;
  localparam int CKE_MIN    = 40;
  localparam int RP_MIN     = 2;
  localparam int RFC_MIN    = 13;
  localparam int MRD_MIN    = 2;
  localparam int OCD_MIN    = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cfgCasLat, cfgAddLat, cfgBurstLen, cfgWrRec;
  logic [1:0] cfgRtt;
  logic memCke, memCsN, memRasN, memCasN, memWeN, memOdt, initDone;
  logic [2:0]  memBa;
  logic [13:0] memAddr;

  always #5 clk = ~clk;

  ddr2_init_seq #(.NUM_REF(NREF)) u_ddr2_init_seq (
    .clk(clk), .rstN(rstN),
    .cfgCasLat(cfgCasLat), .cfgAddLat(cfgAddLat), .cfgBurstLen(cfgBurstLen),
    .cfgWrRec(cfgWrRec), .cfgRtt(cfgRtt),
    .memCke(memCke), .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN),
    .memWeN(memWeN), .memBa(memBa), .memAddr(memAddr), .memOdt(memOdt),
    .initDone(initDone)
  );

  typedef struct {
    logic [3:0]  pins;
    logic [2:0]  ba;
    logic [13:0] addr;
    int          minGap;
    bit          ocdChk;
    string       tag;
    string       gapTag;
  } expT;

  expT expQ[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] mrWord(bit dll);
    return {2'b00, cfgWrRec, dll, 1'b0, cfgCasLat, 1'b0, cfgBurstLen};
  endfunction

  function automatic logic [13:0] emr1Word(logic [2:0] ocd);
    return {4'b0000, ocd, cfgRtt[1], cfgAddLat, cfgRtt[0], 2'b00};
  endfunction

  task automatic pushExp(logic [3:0] pins, logic [2:0] ba, logic [13:0] addr,
                         int gap, bit ocd, string tag, string gapTag);
    expT e;
    e.pins = pins; e.ba = ba; e.addr = addr; e.minGap = gap;
    e.ocdChk = ocd; e.tag = tag; e.gapTag = gapTag;
    expQ.push_back(e);
  endtask

  // Driver: expected command list for the current field values
  task automatic expectSeq();
    expQ.delete();
    pushExp(4'b0010, 3'd0, 14'h0400, CKE_MIN, 0, "R2 R3 first precharge-all", "R2");
    pushExp(4'b0000, 3'd2, 14'h0000, RP_MIN,  0, "R3 R5 ext2 write", "R7");
    pushExp(4'b0000, 3'd3, 14'h0000, MRD_MIN, 0, "R3 R5 ext3 write", "R6");
    pushExp(4'b0000, 3'd1, emr1Word(3'b000), MRD_MIN, 0, "R3 R5 ext1 dll enable", "R6");
    pushExp(4'b0000, 3'd0, mrWord(1'b1), MRD_MIN, 0, "R3 R4 main dll reset", "R6");
    pushExp(4'b0010, 3'd0, 14'h0400, MRD_MIN, 0, "R3 second precharge-all", "R6");
    for (int i = 0; i < NREF; i++)
      pushExp(4'b0001, 3'd0, 14'h0000, (i == 0) ? RP_MIN : RFC_MIN, 0,
              "R3 R11 auto-refresh", "R7");
    pushExp(4'b0000, 3'd0, mrWord(1'b0), RFC_MIN, 0, "R3 R4 main run write", "R7");
    pushExp(4'b0000, 3'd1, emr1Word(3'b111), MRD_MIN, 1, "R3 R5 ext1 cal default", "R6");
    pushExp(4'b0000, 3'd1, emr1Word(3'b000), MRD_MIN, 0, "R3 R5 ext1 cal exit", "R6");
  endtask

  // Monitor
  int  cyc, lastCmdCyc, lastPreCyc;
  bit  ckeSeen, doneSeen, odtBad;
  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0; lastCmdCyc = 0; lastPreCyc = 0; ckeSeen = 0; doneSeen = 0;
    end else begin
      logic [3:0] pins;
      cyc++;
      pins = {memCsN, memRasN, memCasN, memWeN};
      if (memOdt) odtBad = 1;
      if (!ckeSeen && memCke) begin
        ckeSeen = 1;
        lastCmdCyc = cyc;
        chk(cyc > STABLE_MIN, "R1", "cke low cycles", cyc - 1, STABLE_MIN);
      end
      if (pins != 4'b0111) begin
        if (expQ.size() == 0) begin
          chk(0, "R9", "unexpected command", pins, 4'b0111);
        end else begin
          expT e;
          e = expQ.pop_front();
          chk({pins, memBa, memAddr} == {e.pins, e.ba, e.addr}, e.tag,
              "cmd/ba/addr", {pins, memBa, memAddr}, {e.pins, e.ba, e.addr});
          chk(cyc - lastCmdCyc >= e.minGap, e.gapTag, "gap cycles",
              cyc - lastCmdCyc, e.minGap);
          if (e.ocdChk)
            chk(cyc - lastPreCyc >= OCD_MIN, "R8", "cycles after precharge-all",
                cyc - lastPreCyc, OCD_MIN);
        end
        if (pins == 4'b0010) lastPreCyc = cyc;
        lastCmdCyc = cyc;
      end
      if (initDone && !doneSeen) begin
        doneSeen = 1;
        chk(expQ.size() == 0, "R9", "commands left at done", expQ.size(), 0);
        chk(cyc - lastCmdCyc >= MRD_MIN, "R9", "done gap", cyc - lastCmdCyc, MRD_MIN);
      end
      if (doneSeen && !initDone) chk(0, "R9", "initDone dropped", 0, 1);
    end
  end

  task automatic resetCheck();
    chk(memCke == 1'b0, "R1", "cke in reset", memCke, 0);
    chk(memOdt == 1'b0, "R1", "odt in reset", memOdt, 0);
    chk(initDone == 1'b0, "R1", "initDone in reset", initDone, 0);
    chk({memCsN, memRasN, memCasN, memWeN} == 4'b0111, "R1", "NOP in reset",
        {memCsN, memRasN, memCasN, memWeN}, 4'b0111);
  endtask

  task automatic runOnce(logic [2:0] cl, logic [2:0] al, logic [2:0] bl,
                         logic [2:0] wr, logic [1:0] rtt);
    @(posedge clk); #1;
    rstN = 1'b0;
    cfgCasLat = cl; cfgAddLat = al; cfgBurstLen = bl; cfgWrRec = wr; cfgRtt = rtt;
    odtBad = 0;
    repeat (3) @(negedge clk);
    resetCheck();
    expectSeq();
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    chk(memCke == 1'b0, "R1", "cke just after release", memCke, 0);
    while (!initDone) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(expQ.size() == 0, "R3", "expected commands not seen", expQ.size(), 0);
    chk(initDone == 1'b1, "R9", "initDone held", initDone, 1);
    chk({memCsN, memRasN, memCasN, memWeN} == 4'b0111, "R9", "NOP after done",
        {memCsN, memRasN, memCasN, memWeN}, 4'b0111);
    chk(odtBad == 0, "R10", "odt went high", odtBad, 0);
  endtask

  initial begin
    cfgCasLat = '0; cfgAddLat = '0; cfgBurstLen = '0; cfgWrRec = '0; cfgRtt = '0;
    odtBad = 0;
    runOnce(3'b101, 3'b000, 3'b010, 3'b001, 2'b01);
    runOnce(3'b111, 3'b110, 3'b011, 3'b101, 2'b10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (120000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule